// File: doc/BRIEF.md
# Host Handshake Byte Transfer Controller

This block moves bytes between an 8-bit host data bus and a byte-wide synchronous buffer memory port. A local CPU sets it up through three load strobes: a byte count, a buffer start address, and a control word. The control word holds an enable, a direction and a mode bit. In handshake mode the block raises a request line. The host answers with an active-low acknowledge, and each completed acknowledge pulse moves one byte. In register mode the host writes a write-data port or reads a read-data port directly, and no request is ever raised.

Each direction has its own small FIFO, two entries deep by default. The buffer address counter steps after every memory access. A transfer counter is decremented for each byte that enters a FIFO. A sticky completion flag rises once the count is exhausted and everything queued has left the FIFOs. The acknowledge input is asynchronous, so it is synchronized before its edges are detected. Clearing the enable bit aborts a transfer: both FIFOs are flushed and the request is withdrawn.

Top module: `hbx_dma_ctrl`

## Requirements
- R1: After reset `host_req`, `host_dout_oe`, `mem_en` and `stat_done` are all 0.
- R2: With enable=1, direction=1 (host to buffer) and mode=0 (handshake), `host_req` rises while the write FIFO has room, the count is nonzero and `host_ack_n` is high. It falls within four clocks of `host_ack_n` going low.
- R3: In handshake host-to-buffer transfers, the byte stored is the value `host_din` held while `host_ack_n` was low. It is taken at the rising edge of `host_ack_n`, and a change of `host_din` at that same edge is not stored. Bytes are written with `mem_we`=1 to consecutive addresses that begin at the loaded start address.
- R4: With direction=0 (buffer to host) in handshake mode, the block first reads the byte at the address counter. It raises `host_req` only after that byte is queued. While `host_ack_n` is held low it drives that byte on `host_dout` with `host_dout_oe`=1.
- R5: Exactly the loaded count of bytes is moved. At zero count no further request is raised, and register-mode writes are ignored, so the memory is left untouched.
- R6: `stat_done` rises only once the count is zero and both FIFOs are empty. Bytes still queued hold it at 0. It stays set until the next control load.
- R7: The address counter steps by one per memory access and wraps from all-ones to zero.
- R8: With mode=1 and direction=1, each `pio_wr` pulse enqueues `pio_wdata` for the memory, and `host_req` stays 0.
- R9: With mode=1 and direction=0, `pio_rdata` shows the oldest fetched byte, and a `pio_rd` pulse removes it.
- R10: With enable=0 `host_req` is 0 and both FIFOs are emptied, so no stale byte appears after the transfer is restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_load | input | 1 | Load the transfer byte count |
| cnt_value | input | CNT_W | Byte count to load |
| addr_load | input | 1 | Load the buffer start address |
| addr_value | input | ADDR_W | Buffer start address |
| ctrl_load | input | 1 | Load the control word; clears the completion flag |
| ctrl_en | input | 1 | Enable the transfer |
| ctrl_dir | input | 1 | 1 = host to buffer, 0 = buffer to host |
| ctrl_pio | input | 1 | 1 = register mode, 0 = handshake mode |
| host_req | output | 1 | Transfer request to the host |
| host_ack_n | input | 1 | Active-low acknowledge from the host (asynchronous) |
| host_din | input | 8 | Host data bus, host to block |
| host_dout | output | 8 | Host data bus, block to host |
| host_dout_oe | output | 1 | Drive enable for `host_dout` |
| pio_wr | input | 1 | Register-mode write strobe |
| pio_wdata | input | 8 | Register-mode write data |
| pio_rd | input | 1 | Register-mode read strobe (removes the shown byte) |
| pio_rdata | output | 8 | Register-mode read data |
| mem_en | output | 1 | Buffer memory access enable |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | ADDR_W | Buffer memory address |
| mem_wdata | output | 8 | Buffer memory write data |
| mem_rdata | input | 8 | Buffer memory read data, valid one clock after a read |
| stat_done | output | 1 | Sticky transfer-complete flag |

## Verification
The embedded properties check several rules on every clock:
- the request falls after a synchronized low acknowledge;
- the host bus drive only occurs during a low acknowledge with a byte queued;
- no request is raised at zero count or with the block disabled, and none in register mode;
- each memory access steps the address by one;
- the completion flag rises only after a drained, exhausted state.

Some properties need the bench's scenarios instead:
- data integrity across the handshake;
- capture of the held byte rather than the one presented at release;
- the address wrap;
- completion being held back while fetched bytes still wait in register mode;
- the flush of stale bytes on disable.

// File: rtl/hbx_pkg.sv
// Shared definitions for the host handshake byte transfer controller.
package hbx_pkg;
    // Width of the host bus and of a buffer memory word.
    localparam int HBX_DW = 8;

    // Direction of a transfer as seen from the host.
    typedef enum logic {
        DIR_TO_HOST   = 1'b0,
        DIR_FROM_HOST = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/hbx_ack_sync.sv
// Synchronizes the asynchronous active-low acknowledge and flags its
// release (rising edge). A data delay line of equal depth keeps the host
// byte aligned with the oldest acknowledge sample, so that on a release the
// held output is the byte that was on the bus while acknowledge was low.
// Assumes the host keeps its data stable while acknowledge is low.
module hbx_ack_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_n_raw,
    input  logic [W-1:0] data_raw,
    output logic         ack_high,
    output logic         ack_rise,
    output logic [W-1:0] data_held
);
    logic s1, s2, s3;
    logic [W-1:0] d1, d2, d3;

    // Three-stage sample chains for acknowledge and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
            d1 <= '0;
            d2 <= '0;
            d3 <= '0;
        end else begin
            s1 <= ack_n_raw;
            s2 <= s1;
            s3 <= s2;
            d1 <= data_raw;
            d2 <= d1;
            d3 <= d2;
        end
    end

    assign ack_high  = s2;
    assign ack_rise  = s2 & ~s3;
    assign data_held = d3;
endmodule

// File: rtl/hbx_fifo.sv
// Small ring-buffer FIFO with synchronous flush. A push when full and a pop
// when empty are dropped. The head entry is shown on dout at all times.
module hbx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    // Next ring position, wrapping at DEPTH.
    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = slots[rp];

    // Pointer and occupancy update; flush empties the ring.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                slots[wp] <= din;
                wp        <= nxt(wp);
            end
            if (do_pop) begin
                rp <= nxt(rp);
            end
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/hbx_dma_ctrl.sv
// Host handshake byte transfer controller (top).
// Moves bytes between an 8-bit host bus and a synchronous buffer memory.
// It supports a request/acknowledge mode and a direct register mode.
// Each direction uses a small FIFO. A transfer counter is decremented on
// every FIFO entry, and a sticky completion flag is raised.
// Assumes: a memory read returns data one clock after mem_en with mem_we=0.
// Assumes: the CPU disables the block before it reloads count or address.
module hbx_dma_ctrl
    import hbx_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic              ctrl_load,
    input  logic              ctrl_en,
    input  logic              ctrl_dir,
    input  logic              ctrl_pio,
    output logic              host_req,
    input  logic              host_ack_n,
    input  logic [HBX_DW-1:0] host_din,
    output logic [HBX_DW-1:0] host_dout,
    output logic              host_dout_oe,
    input  logic              pio_wr,
    input  logic [HBX_DW-1:0] pio_wdata,
    input  logic              pio_rd,
    output logic [HBX_DW-1:0] pio_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [HBX_DW-1:0] mem_wdata,
    input  logic [HBX_DW-1:0] mem_rdata,
    output logic              stat_done
);
    // Control state.
    logic              en_q, pio_q;
    xfer_dir_e         dir_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              pend_q, rd_pend_q, done_q;

    // Synchronized acknowledge.
    logic              ack_high, ack_rise;
    logic [HBX_DW-1:0] held_byte;

    // FIFO handshakes.
    logic              wpush, wpop, wfull, wempty;
    logic              rpush, rpop, rfull, rempty;
    logic [HBX_DW-1:0] wdin, wdout, rdout;

    // Mode decodes.
    logic dma_h2b, dma_b2h, pio_h2b, pio_b2h, cnt_nz, rd_issue, req_ok, flush;

    hbx_ack_sync #(.W(HBX_DW)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_n_raw (host_ack_n),
        .data_raw  (host_din),
        .ack_high  (ack_high),
        .ack_rise  (ack_rise),
        .data_held (held_byte)
    );

    assign dma_h2b = en_q & ~pio_q & (dir_q == DIR_FROM_HOST);
    assign dma_b2h = en_q & ~pio_q & (dir_q == DIR_TO_HOST);
    assign pio_h2b = en_q &  pio_q & (dir_q == DIR_FROM_HOST);
    assign pio_b2h = en_q &  pio_q & (dir_q == DIR_TO_HOST);
    assign cnt_nz  = (cnt_q != '0);
    assign flush   = ~en_q;

    // Write path: host byte enters on acknowledge release or register write.
    assign wpush = cnt_nz & ~wfull &
                   ((dma_h2b & pend_q & ack_rise) | (pio_h2b & pio_wr));
    assign wdin  = pio_q ? pio_wdata : held_byte;
    assign wpop  = en_q & ~wempty;

    hbx_fifo #(.W(HBX_DW), .DEPTH(FIFO_DEPTH)) u_wfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (wpush),
        .din   (wdin),
        .pop   (wpop),
        .dout  (wdout),
        .full  (wfull),
        .empty (wempty)
    );

    // Read path: one memory read in flight at a time, landing in the FIFO.
    assign rd_issue = en_q & (dir_q == DIR_TO_HOST) & cnt_nz & ~rd_pend_q & ~rfull;
    assign rpush    = en_q & rd_pend_q;
    assign rpop     = (dma_b2h & pend_q & ack_rise) | (pio_b2h & pio_rd);

    hbx_fifo #(.W(HBX_DW), .DEPTH(FIFO_DEPTH)) u_rfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rpush),
        .din   (mem_rdata),
        .pop   (rpop),
        .dout  (rdout),
        .full  (rfull),
        .empty (rempty)
    );

    // Buffer memory port.
    assign mem_en    = wpop | rd_issue;
    assign mem_we    = wpop;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdout;

    // Host-side outputs.
    assign host_dout    = rdout;
    assign host_dout_oe = dma_b2h & pend_q & ~ack_high;
    assign pio_rdata    = rdout;
    assign stat_done    = done_q;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dir_q <= DIR_TO_HOST;
            pio_q <= 1'b0;
        end else if (ctrl_load) begin
            en_q  <= ctrl_en;
            dir_q <= xfer_dir_e'(ctrl_dir);
            pio_q <= ctrl_pio;
        end
    end

    // Transfer counter: one step down per byte entering a FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_load) begin
            cnt_q <= cnt_value;
        end else if (wpush | rpush) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Buffer address counter: steps after every memory access, wraps freely.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_load) begin
            addr_q <= addr_value;
        end else if (mem_en) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // In-flight memory read marker.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) begin
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= rd_issue;
        end
    end

    // Request condition for the current direction.
    assign req_ok = dma_h2b ? (~wfull & cnt_nz) : (dma_b2h & ~rempty);

    // Request/acknowledge handshake: raise, drop on acknowledge, retire on release.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q || pio_q) begin
            host_req <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (host_req && !ack_high) begin
                host_req <= 1'b0;
            end
            if (pend_q && ack_rise) begin
                pend_q <= 1'b0;
            end else if (!pend_q && ack_high && req_ok) begin
                host_req <= 1'b1;
                pend_q   <= 1'b1;
            end
        end
    end

    // Sticky completion flag: count exhausted and everything drained.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_load) begin
            done_q <= 1'b0;
        end else if (en_q && !cnt_nz && wempty && rempty && !rd_pend_q && !pend_q) begin
            done_q <= 1'b1;
        end
    end

    p_req_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !ack_high) |=> !host_req);
    p_zero_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_h2b && !cnt_nz && !cnt_load && !ctrl_load) |=> !host_req);
    p_drive_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_dout_oe |-> (!ack_high && !rempty));
    p_done_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_done) |-> $past(!cnt_nz && wempty && rempty));
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !addr_load) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
    p_pio_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_q && $past(pio_q)) |-> !host_req);
    p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctrl_load) |=> !host_req);
endmodule

// File: tb/test_hbx_dma_ctrl.sv
// Scoreboard bench: driver tasks queue expected memory writes and host reads,
// a monitor compares memory writes as they appear.
module test_hbx_dma_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_load = 1'b0;
    logic [7:0] cnt_value = '0;
    logic       addr_load = 1'b0;
    logic [7:0] addr_value = '0;
    logic       ctrl_load = 1'b0, ctrl_en = 1'b0, ctrl_dir = 1'b0, ctrl_pio = 1'b0;
    logic       host_req;
    logic       host_ack_n = 1'b1;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       host_dout_oe;
    logic       pio_wr = 1'b0;
    logic [7:0] pio_wdata = '0;
    logic       pio_rd = 1'b0;
    logic [7:0] pio_rdata;
    logic       mem_en, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic       stat_done;

    int total = 0;
    int bad = 0;
    logic [15:0] wr_exp_q[$];
    logic [7:0]  mem [256];

    always #5 clk = ~clk;

    hbx_dma_ctrl i_hbx_dma_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cnt_load(cnt_load), .cnt_value(cnt_value),
        .addr_load(addr_load), .addr_value(addr_value),
        .ctrl_load(ctrl_load), .ctrl_en(ctrl_en), .ctrl_dir(ctrl_dir), .ctrl_pio(ctrl_pio),
        .host_req(host_req), .host_ack_n(host_ack_n), .host_din(host_din),
        .host_dout(host_dout), .host_dout_oe(host_dout_oe),
        .pio_wr(pio_wr), .pio_wdata(pio_wdata), .pio_rd(pio_rd), .pio_rdata(pio_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .stat_done(stat_done)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(a ^ 8'h3C);
    endfunction

    // Buffer memory model: synchronous, one-clock read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
        end else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every memory write must match the head of the expected queue (R3).
    always @(negedge clk) begin
        if (rst_n && mem_en && mem_we) begin
            if (wr_exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = wr_exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R3 memory write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input bit en, input bit dir, input bit pio);
        @(negedge clk);
        ctrl_load = 1'b1; ctrl_en = en; ctrl_dir = dir; ctrl_pio = pio;
        @(negedge clk);
        ctrl_load = 1'b0;
    endtask

    task automatic setup(input logic [7:0] a, input logic [7:0] n);
        set_ctrl(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        addr_load = 1'b1; addr_value = a; cnt_load = 1'b1; cnt_value = n;
        @(negedge clk);
        addr_load = 1'b0; cnt_load = 1'b0;
    endtask

    task automatic wait_req(output bit got);
        int k = 0;
        @(negedge clk);
        while (!host_req && k < 200) begin
            @(negedge clk);
            k++;
        end
        got = host_req;
    endtask

    task automatic wait_drop(output bit dropped);
        int k = 0;
        while (host_req && k < 4) begin
            @(negedge clk);
            k++;
        end
        dropped = !host_req;
    endtask

    // Driver: one handshake byte from the host; queues the expected write.
    task automatic host_write(input logic [7:0] b, input logic [7:0] a);
        bit got, dropped;
        wait_req(got);
        check(got, "R2 request raised", host_req, 1);
        wr_exp_q.push_back({a, b});
        host_din = b;
        host_ack_n = 1'b0;
        @(negedge clk);
        wait_drop(dropped);
        check(dropped, "R2 request dropped", host_req, 0);
        tick(1);
        host_ack_n = 1'b1;
        host_din = 8'h5A;   // R3: change at release must not be stored
        tick(1);
    endtask

    // Driver: one handshake byte to the host, compared on the bus.
    task automatic host_read(input logic [7:0] exp);
        bit got, dropped;
        wait_req(got);
        check(got, "R4 request raised", host_req, 1);
        host_ack_n = 1'b0;
        @(negedge clk);
        wait_drop(dropped);
        check(dropped, "R2 request dropped", host_req, 0);
        tick(1);
        check(host_dout_oe == 1'b1, "R4 drive enable", host_dout_oe, 1);
        check(host_dout == exp, "R4 host data", host_dout, exp);
        host_ack_n = 1'b1;
        tick(1);
    endtask

    task automatic pio_write(input logic [7:0] b);
        @(negedge clk);
        pio_wr = 1'b1; pio_wdata = b;
        @(negedge clk);
        pio_wr = 1'b0;
    endtask

    task automatic pio_read;
        @(negedge clk);
        pio_rd = 1'b1;
        @(negedge clk);
        pio_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check(host_req == 0, "R1 request", host_req, 0);
        check(host_dout_oe == 0, "R1 drive enable", host_dout_oe, 0);
        check(mem_en == 0, "R1 memory idle", mem_en, 0);
        check(stat_done == 0, "R1 done", stat_done, 0);

        // Handshake host to buffer, three bytes at 0x10 (R2, R3, R5, R6)
        setup(8'h10, 8'd3);
        set_ctrl(1'b1, 1'b1, 1'b0);
        host_write(8'hA1, 8'h10);
        tick(3);
        check(stat_done == 0, "R6 done early", stat_done, 0);
        host_write(8'hB2, 8'h11);
        host_write(8'hC3, 8'h12);
        tick(10);
        check(host_req == 0, "R5 no request at zero count", host_req, 0);
        check(stat_done == 1, "R6 done after drain", stat_done, 1);
        check(wr_exp_q.size() == 0, "R3 all bytes written", wr_exp_q.size(), 0);

        // Address wrap (R7)
        setup(8'hFF, 8'd2);
        set_ctrl(1'b1, 1'b1, 1'b0);
        host_write(8'h77, 8'hFF);
        host_write(8'h88, 8'h00);
        tick(8);
        check(wr_exp_q.size() == 0, "R7 wrap writes", wr_exp_q.size(), 0);

        // Handshake buffer to host, three bytes from 0x40 (R4, R5, R6)
        setup(8'h40, 8'd3);
        set_ctrl(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) host_read(pat(8'h40 + i));
        tick(6);
        check(host_req == 0, "R5 no request at zero count", host_req, 0);
        check(stat_done == 1, "R6 done after reads", stat_done, 1);

        // Register mode write (R8, R5)
        setup(8'h80, 8'd2);
        set_ctrl(1'b1, 1'b1, 1'b1);
        wr_exp_q.push_back({8'h80, 8'h11});
        wr_exp_q.push_back({8'h81, 8'h22});
        pio_write(8'h11);
        check(host_req == 0, "R8 request stays low", host_req, 0);
        pio_write(8'h22);
        pio_write(8'h33);
        tick(6);
        check(wr_exp_q.size() == 0, "R8 register writes", wr_exp_q.size(), 0);
        check(mem[8'h82] == pat(8'h82), "R5 write past count ignored", mem[8'h82], pat(8'h82));
        check(stat_done == 1, "R6 done register write", stat_done, 1);

        // Register mode read; done waits for the FIFO to drain (R9, R6)
        setup(8'h90, 8'd2);
        set_ctrl(1'b1, 1'b0, 1'b1);
        tick(8);
        check(stat_done == 0, "R6 done held while queued", stat_done, 0);
        check(pio_rdata == pat(8'h90), "R9 first byte", pio_rdata, pat(8'h90));
        pio_read();
        check(pio_rdata == pat(8'h91), "R9 second byte", pio_rdata, pat(8'h91));
        check(stat_done == 0, "R6 done held one queued", stat_done, 0);
        pio_read();
        tick(2);
        check(stat_done == 1, "R6 done after read drain", stat_done, 1);

        // Disable flushes stale bytes (R10)
        setup(8'hA0, 8'd4);
        set_ctrl(1'b1, 1'b0, 1'b1);
        tick(8);
        check(pio_rdata == pat(8'hA0), "R10 queued before flush", pio_rdata, pat(8'hA0));
        setup(8'hB0, 8'd1);
        check(host_req == 0, "R10 request low when disabled", host_req, 0);
        set_ctrl(1'b1, 1'b0, 1'b1);
        tick(6);
        check(pio_rdata == pat(8'hB0), "R10 no stale byte", pio_rdata, pat(8'hB0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule